// File: doc/BRIEF.md
# Latched Serial-to-Parallel Display Driver Logic

This block takes a serial bit stream, clocks it into a chain of stages on every rising clock edge, and presents the chain contents in parallel through a bank of level-sensitive latches and a conditioning stage. It drives display column or segment lines, with the high-voltage part left outside the logic. The chain shifts on its own. The latch enable, the blanking control and the polarity control change only what reaches the parallel outputs. A serial output shows the far end of the chain, so several devices can be chained into one long register.

Two controls choose among four output modes. The outputs can follow the latched data as it is, follow its inverse, be forced all high, or be forced all low. A parameter sets which end of the parallel bus the serial data enters, so one design serves both pin rotations.

Top module: `serial_latch_driver`

## Requirements
- R1: With REVERSE=0, each rising edge of clk_i moves the chain by one stage. sdata_i enters the stage that drives par_o[0], and stage i moves to stage i+1.
- R2: sdata_o always equals the last stage. With REVERSE=0 that stage is the one driving par_o[N-1], so a bit applied at edge k appears on sdata_o after edge k+N-1.
- R3: le_i, blank_ni and pol_i have no effect on the chain contents or on sdata_o.
- R4: While le_i is 1, the latches pass the chain contents through to the conditioning stage.
- R5: While le_i is 0, the latches keep the value they held when le_i fell, whatever the chain does.
- R6: blank_ni=0 with pol_i=0 forces every bit of par_o to 1.
- R7: blank_ni=0 with pol_i=1 forces every bit of par_o to 0.
- R8: blank_ni=1 with pol_i=0 makes each par_o bit the inverse of its latch bit.
- R9: blank_ni=1 with pol_i=1 makes each par_o bit equal its latch bit.
- R10: With REVERSE=1, sdata_i enters the stage that drives par_o[N-1], data moves toward par_o[0], and sdata_o shows the stage that drives par_o[0].
- R11: rst_ni=0 clears the chain and the latches to 0 at once, without waiting for a clock edge.
- R12: When two instances are chained (sdata_o of the first drives sdata_i of the second), 2N clocks followed by a latch pulse place a 2N-bit pattern across both parallel buses. The first instance holds the newest N bits. The bus pattern is correct in all four output modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data in |
| le_i | input | 1 | Latch enable, 1 = transparent |
| blank_ni | input | 1 | Active-low blanking |
| pol_i | input | 1 | Polarity select |
| par_o | output | N | Conditioned parallel outputs |
| sdata_o | output | 1 | Serial cascade output (last stage) |

## Verification
A wrong stage in the chain reaches par_o as soon as the latches are transparent. It reaches sdata_o only when that bit arrives at the far end, up to N clocks later. With two devices chained, the second device shows it after the bit has crossed both chains. A latch that fails to hold shows up on par_o within one clock of le_i going low, because the chain keeps moving underneath it. A mode decode that is wrong is visible at once on every output bit, without a clock edge, as soon as blank_ni or pol_i is set.

// File: rtl/sld_pkg.sv
package sld_pkg;
  typedef enum logic [1:0] {
    MODE_FORCE_HI = 2'd0,
    MODE_FORCE_LO = 2'd1,
    MODE_INVERT   = 2'd2,
    MODE_PASS     = 2'd3
  } out_mode_e;

  function automatic out_mode_e decode_mode(input logic blank_n, input logic pol);
    case ({blank_n, pol})
      2'b00:   decode_mode = MODE_FORCE_HI;
      2'b01:   decode_mode = MODE_FORCE_LO;
      2'b10:   decode_mode = MODE_INVERT;
      default: decode_mode = MODE_PASS;
    endcase
  endfunction
endpackage

// File: rtl/sld_shift_reg.sv
module sld_shift_reg #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         din_i,
  output logic [N-1:0] chain_o,
  output logic         dout_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[N-2:0], din_i};
  end

  assign chain_o = q;
  assign dout_o  = q[N-1];

  AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q[0] == $past(din_i)); // R1
  AST_SHIFT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> dout_o == $past(q[N-2])); // R2
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
  parameter int N = 32
) (
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_latch begin
    if (!rst_ni)   q_o = '0;
    else if (le_i) q_o = d_i;
  end
endmodule

// File: rtl/sld_out_stage.sv
module sld_out_stage
  import sld_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         blank_ni,
  input  logic         pol_i,
  input  logic [N-1:0] lat_i,
  output logic [N-1:0] out_o
);
  out_mode_e mode;
  assign mode = decode_mode(blank_ni, pol_i);

  always_comb begin
    case (mode)
      MODE_FORCE_HI: out_o = '1;
      MODE_FORCE_LO: out_o = '0;
      MODE_INVERT:   out_o = ~lat_i;
      default:       out_o = lat_i;
    endcase
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int N       = 32,
  parameter bit REVERSE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdata_i,
  input  logic         le_i,
  input  logic         blank_ni,
  input  logic         pol_i,
  output logic [N-1:0] par_o,
  output logic         sdata_o
);
  logic [N-1:0] chain;
  logic [N-1:0] sr_ord;
  logic [N-1:0] lat_q;

  sld_shift_reg #(.N(N)) u_sr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (sdata_i),
    .chain_o(chain),
    .dout_o (sdata_o)
  );

  // map chain stages onto output positions
  for (genvar i = 0; i < N; i++) begin : g_ord
    if (REVERSE) begin : g_rev
      assign sr_ord[i] = chain[N-1-i];
    end else begin : g_fwd
      assign sr_ord[i] = chain[i];
    end
  end

  sld_latch_bank #(.N(N)) u_lat (
    .rst_ni(rst_ni),
    .le_i  (le_i),
    .d_i   (sr_ord),
    .q_o   (lat_q)
  );

  sld_out_stage #(.N(N)) u_out (
    .blank_ni(blank_ni),
    .pol_i   (pol_i),
    .lat_i   (lat_q),
    .out_o   (par_o)
  );

  AST_LATCH_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |-> lat_q == sr_ord); // R4
  AST_FORCE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_ni && !pol_i) |-> &par_o); // R6
  AST_FORCE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_ni && pol_i) |-> par_o == '0); // R7
  AST_PASS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && pol_i) |-> par_o == lat_q); // R9
endmodule

// File: tb/sim_serial_latch_driver.sv
module sim_serial_latch_driver;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk, rst_n, sdata, le, blank_n, pol;
  logic [N-1:0] par0, par1, par2;
  logic sd0, sd1, sd2;

  serial_latch_driver #(.N(N), .REVERSE(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .le_i(le),
    .blank_ni(blank_n), .pol_i(pol), .par_o(par0), .sdata_o(sd0));
  serial_latch_driver #(.N(N), .REVERSE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sd0), .le_i(le),
    .blank_ni(blank_n), .pol_i(pol), .par_o(par1), .sdata_o(sd1));
  serial_latch_driver #(.N(N), .REVERSE(1'b1)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .le_i(le),
    .blank_ni(blank_n), .pol_i(pol), .par_o(par2), .sdata_o(sd2));

  item_t sb_q[$];
  event  chk_ev;
  int    checks = 0;
  int    errors = 0;
  logic [63:0] m;     // m[0] = newest bit
  logic [63:0] held;  // model of latched chain

  function automatic logic [31:0] cond(input logic [31:0] l);
    if (!blank_n) return pol ? 32'h0 : 32'hffff_ffff;
    return pol ? l : ~l;
  endfunction

  function automatic logic [31:0] bitrev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] pick(input int sel);
    case (sel)
      0: return par0;
      1: return par1;
      2: return par2;
      3: return {31'b0, sd0};
      4: return {31'b0, sd1};
      default: return {31'b0, sd2};
    endcase
  endfunction

  task automatic push(input int sel, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // driver side: expected items from the model
  task automatic expect_all(input string tag);
    push(0, cond(held[31:0]), tag);
    push(1, cond(held[63:32]), tag);
    push(2, cond(bitrev(held[31:0])), {tag, " R10"});
    push(3, {31'b0, m[31]}, {tag, " R2"});
    push(4, {31'b0, m[63]}, {tag, " R12"});
    push(5, {31'b0, m[31]}, {tag, " R10"});
    -> chk_ev;
    #1;
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    #1 clk = 1'b1;
    m = {m[62:0], b};
    if (le) held = m;
    #4 clk = 1'b0;
    #5;
  endtask

  task automatic set_le(input logic v);
    le = v;
    if (v) held = m;
    #1;
  endtask

  task automatic set_mode(input logic bn, input logic p);
    blank_n = bn; pol = p;
    #1;
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = pick(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    clk = 0; rst_n = 0; sdata = 0; le = 1; blank_n = 1; pol = 1;
    m = '0; held = '0;
    #10;
    expect_all("R11 reset state");
    rst_n = 1;
    #5;

    // R1 R4 R9: transparent pass mode, bit by bit
    pat = 64'hA5C3_0F96_1E2D_B478;
    for (int k = 0; k < 40; k++) begin
      shift_bit(pat[k]);
      expect_all("R1 R4 R9");
    end

    // R3 R5: hold latches, toggle controls while shifting
    set_le(0);
    for (int k = 0; k < 8; k++) begin
      set_mode(k[0], k[1]);
      shift_bit(pat[40+k]);
      expect_all("R3 R5 R6 R7 R8");
    end
    set_mode(1, 1);
    expect_all("R5 held");
    set_le(1);
    expect_all("R3 R4 chain unaffected");

    // R12: cascade fill with latches closed, then pulse
    set_le(0);
    pat = 64'h0123_4567_89AB_CDEF;
    for (int k = 0; k < 64; k++) shift_bit(pat[63-k]);
    expect_all("R5 R12 before pulse");
    set_le(1);
    set_le(0);
    if (held !== pat) begin
      errors++;
      $display("FAIL R12 model actual=%h expected=%h", held, pat);
    end
    checks++;
    set_mode(0, 0); expect_all("R12 R6");
    set_mode(0, 1); expect_all("R12 R7");
    set_mode(1, 0); expect_all("R12 R8");
    set_mode(1, 1); expect_all("R12 R9");

    // R5: chain moves, latches do not
    shift_bit(1'b1);
    shift_bit(1'b0);
    expect_all("R5 R3 after pulse");

    // R11: asynchronous reset with clock idle
    #2 rst_n = 0;
    m = '0; held = '0;
    #1;
    expect_all("R11 async reset");
    rst_n = 1;
    #5;
    set_le(1);
    shift_bit(1'b1);
    expect_all("R1 R11 after reset");

    #5;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule